// File: doc/BRIEF.md
# Byte-Wide Synchronous Serial Port

This block is a full-duplex synchronous serial port that hangs off a small byte-wide processor bus. Software sees three byte registers: a control byte, a status byte and a data byte. In master mode, a write to the data register goes straight into the 8-bit shift register and the transfer starts at once. The block then produces eight serial clock cycles. One bit leaves and one bit arrives in each cycle, most significant bit first. After the eighth cycle, the received byte drops into a receive buffer and a completion flag rises.

There is no transmit holding register, so a data write made while a transfer is running is refused and flagged as a collision. The receive side is buffered: the received byte stays readable until the next transfer completes. Both flags are cleared by the same two-step sequence: software reads the status byte while a flag is set, then reads or writes the data register. In slave mode the port shifts on a serial clock and select supplied from outside. Those inputs are synchronised to the system clock before use.

Top module: `spi_port`

## Requirements
- R1: Control sits at address 0x0A with bits 7..0 = interrupt enable, port enable, unused (reads 0), master select, clock polarity, clock phase, rate bit 1, rate bit 0. Status sits at 0x0B with transfer-complete at bit 7, write-collision at bit 6 and mode-fault at bit 4; mode-fault and all other status bits read 0. Data sits at 0x0C. Control and both flags reset to 0.
- R2: A data write made while the port is idle loads the shift register. A transfer starts on that write only when port enable and master select are both 1; otherwise no serial clock is produced and no flag rises.
- R3: In master mode, one serial clock period lasts 2, 4, 16 or 32 system clocks for rate bits 00, 01, 10, 11. While no transfer runs, the serial clock output rests at the polarity bit.
- R4: A transfer is eight serial clock cycles, MSB first, full duplex. With phase 0, the first bit is presented before the first edge, input is sampled on leading edges and output changes on trailing edges. With phase 1, output changes on leading edges and input is sampled on trailing edges.
- R5: In master mode, transfer-complete reads 1 exactly 8 × divisor system clocks after the clock edge that accepted the data write. In that same clock, the received byte becomes readable at the data address.
- R6: Transfer-complete and write-collision clear only after a status read made while either flag is set, followed by a read or write of the data address. A data read alone leaves the flags set.
- R7: A data write made during a transfer sets write-collision and is otherwise ignored: both the byte shifted out and the byte received are those of the running transfer.
- R8: The interrupt output is 1 exactly when interrupt enable and transfer-complete are both 1.
- R9: In slave mode (port enable 1, master select 0), the port shifts only while the select input is low. It uses the external serial clock and data input under the same polarity and phase rules, and raises transfer-complete after eight external clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_rd | input | 1 | Read strobe, one clock per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| sclk_o | output | 1 | Serial clock driven in master mode |
| mosi_o | output | 1 | Serial data out in master mode |
| miso_i | input | 1 | Serial data in in master mode |
| sclk_i | input | 1 | Serial clock received in slave mode |
| ss_n_i | input | 1 | Active-low select in slave mode |
| mosi_i | input | 1 | Serial data in in slave mode |
| miso_o | output | 1 | Serial data out in slave mode |

## Verification
The bench plays a slave device against the port in all four polarity and phase combinations and at every rate. It checks the flag timing to the exact clock with the interrupt line, so a divider that is off by one half-period moves the flag and gets reported. It reads the data register before the status register, so a design that clears the flag on any data access fails that check. It also writes during a running transfer: a design that reloads the shift register on that write returns the wrong outgoing byte and misses the collision flag. Slave transfers are driven through the synchronised external clock, which exposes sampling on the wrong edge. A write with the port disabled must produce no clock activity and no flag.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam logic [7:0] ADDR_CTRL = 8'h0A;
  localparam logic [7:0] ADDR_STAT = 8'h0B;
  localparam logic [7:0] ADDR_DATA = 8'h0C;

  localparam int B_IE   = 7;
  localparam int B_EN   = 6;
  localparam int B_MSTR = 4;
  localparam int B_CPOL = 3;
  localparam int B_CPHA = 2;
  localparam logic [7:0] CTRL_MASK = 8'hDF;

  localparam int HALF_W = 5;

  // system clocks per serial clock half period
  function automatic logic [HALF_W-1:0] half_period(input logic [1:0] rate);
    case (rate)
      2'b00:   return HALF_W'(1);
      2'b01:   return HALF_W'(2);
      2'b10:   return HALF_W'(8);
      default: return HALF_W'(16);
    endcase
  endfunction

  function automatic logic [7:0] status_byte(input logic done_f, input logic coll_f);
    return {done_f, coll_f, 6'b000000};
  endfunction
endpackage

// File: rtl/spi_rate_div.sv
module spi_rate_div
  import spi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick
);
  logic [HALF_W-1:0] cnt;
  logic [HALF_W-1:0] limit;

  assign limit = half_period(rate) - HALF_W'(1);
  assign tick  = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + HALF_W'(1);
  end

  a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= limit));
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          lead,
  input  logic          trail,
  input  logic          abort,
  input  logic          cpha,
  input  logic          sdi,
  output logic          sdo,
  output logic [DW-1:0] rx_word,
  output logic          done,
  output logic          inflight
);
  localparam int CNTW = $clog2(DW);
  localparam logic [CNTW-1:0] LAST = CNTW'(DW - 1);

  logic [DW-1:0]   shreg;
  logic [CNTW-1:0] bitcnt;
  logic            cap_bit;
  logic            out_bit;
  logic            bit_in;

  assign bit_in  = cpha ? sdi : cap_bit;
  assign rx_word = {shreg[DW-2:0], bit_in};
  assign done    = trail && !load && !abort && (bitcnt == LAST);
  assign sdo     = cpha ? out_bit : shreg[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      bitcnt   <= '0;
      cap_bit  <= 1'b0;
      out_bit  <= 1'b0;
      inflight <= 1'b0;
    end else if (load) begin
      shreg    <= load_data;
      bitcnt   <= '0;
      inflight <= 1'b0;
    end else if (abort) begin
      bitcnt   <= '0;
      inflight <= 1'b0;
    end else begin
      if (lead) begin
        inflight <= 1'b1;
        if (cpha) out_bit <= shreg[DW-1];
        else      cap_bit <= sdi;
      end
      if (trail) begin
        shreg <= rx_word;
        if (bitcnt == LAST) begin
          bitcnt   <= '0;
          inflight <= 1'b0;
        end else begin
          bitcnt <= bitcnt + CNTW'(1);
        end
      end
    end
  end

  a_r4_shift_only_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!lead && !trail && !load) |=> $stable(shreg));
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic          sclk_o,
  output logic          mosi_o,
  input  logic          miso_i,
  input  logic          sclk_i,
  input  logic          ss_n_i,
  input  logic          mosi_i,
  output logic          miso_o
);
  logic [7:0] ctrl;
  logic       spif, wcol, armed;
  logic       busy, phase, sclk_q;
  logic [DW-1:0] rx_buf;

  logic c_ie, c_en, c_mstr, c_cpol, c_cpha;
  assign c_ie   = ctrl[B_IE];
  assign c_en   = ctrl[B_EN];
  assign c_mstr = ctrl[B_MSTR];
  assign c_cpol = ctrl[B_CPOL];
  assign c_cpha = ctrl[B_CPHA];

  // bus decode events
  logic ctrl_wr, stat_rd, data_wr, data_acc;
  assign ctrl_wr  = bus_wr && (bus_addr == AW'(ADDR_CTRL));
  assign stat_rd  = bus_rd && (bus_addr == AW'(ADDR_STAT));
  assign data_wr  = bus_wr && (bus_addr == AW'(ADDR_DATA));
  assign data_acc = (bus_wr || bus_rd) && (bus_addr == AW'(ADDR_DATA));

  // slave input synchronisers
  logic sclk_s1, sclk_s2, sclk_s3, mosi_s1, mosi_s2, ss_s1, ss_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {sclk_s1, sclk_s2, sclk_s3} <= 3'b000;
      {mosi_s1, mosi_s2}          <= 2'b00;
      {ss_s1, ss_s2}              <= 2'b11;
    end else begin
      sclk_s1 <= sclk_i; sclk_s2 <= sclk_s1; sclk_s3 <= sclk_s2;
      mosi_s1 <= mosi_i; mosi_s2 <= mosi_s1;
      ss_s1   <= ss_n_i; ss_s2   <= ss_s1;
    end
  end

  logic slave_sel, s_edge, lead_s, trail_s;
  assign slave_sel = c_en && !c_mstr && !ss_s2;
  assign s_edge    = sclk_s2 ^ sclk_s3;
  assign lead_s    = slave_sel && s_edge && (sclk_s2 != c_cpol);
  assign trail_s   = slave_sel && s_edge && (sclk_s2 == c_cpol);

  // master serial clock generation
  logic tick, lead_m, trail_m;
  spi_rate_div u_div (
    .clk (clk), .rst_n (rst_n), .run (busy), .rate (ctrl[1:0]), .tick (tick)
  );
  assign lead_m  = tick && !phase;
  assign trail_m = tick && phase;

  // transfer bookkeeping between the register side and the shifter
  logic core_infl, core_done, busy_any, load_req, start_req;
  logic [DW-1:0] rx_word;
  assign busy_any  = busy || core_infl;
  assign load_req  = data_wr && !busy_any;
  assign start_req = load_req && c_en && c_mstr;

  spi_shift_core #(.DW(DW)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_req),
    .load_data (bus_wdata),
    .lead      (c_mstr ? lead_m  : lead_s),
    .trail     (c_mstr ? trail_m : trail_s),
    .abort     (!c_mstr && !slave_sel),
    .cpha      (c_cpha),
    .sdi       (c_mstr ? miso_i : mosi_s2),
    .sdo       (mosi_o),
    .rx_word   (rx_word),
    .done      (core_done),
    .inflight  (core_infl)
  );
  assign miso_o = mosi_o;
  assign sclk_o = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      phase  <= 1'b0;
      sclk_q <= 1'b0;
    end else if (start_req) begin
      busy   <= 1'b1;
      phase  <= 1'b0;
      sclk_q <= c_cpol;
    end else if (busy) begin
      if (tick) begin
        phase  <= ~phase;
        sclk_q <= ~sclk_q;
      end
      if (core_done) busy <= 1'b0;
    end else begin
      sclk_q <= c_cpol;
    end
  end

  // registers and flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      spif   <= 1'b0;
      wcol   <= 1'b0;
      armed  <= 1'b0;
      rx_buf <= '0;
    end else begin
      if (ctrl_wr) ctrl <= bus_wdata[7:0] & CTRL_MASK;
      if (core_done) rx_buf <= rx_word;

      if (stat_rd && (spif || wcol)) armed <= 1'b1;
      else if (data_acc)             armed <= 1'b0;

      if (core_done)               spif <= 1'b1;
      else if (data_acc && armed)  spif <= 1'b0;

      if (data_wr && busy_any)     wcol <= 1'b1;
      else if (data_acc && armed)  wcol <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(ADDR_CTRL))      bus_rdata = DW'(ctrl);
    else if (bus_addr == AW'(ADDR_STAT)) bus_rdata = DW'(status_byte(spif, wcol));
    else if (bus_addr == AW'(ADDR_DATA)) bus_rdata = rx_buf;
  end

  assign irq = c_ie && spif;

  a_r2_start_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(data_wr && c_en && c_mstr));
  a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ctrl_wr) |=> (sclk_o == c_cpol));
  a_r5_flag_after_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spif) |-> $past(busy_any));
  a_r6_clear_by_sequence: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spif) |-> $past(data_acc && armed));
  a_r7_collision: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && busy_any) |=> wcol);
  a_r8_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(core_done || ctrl_wr));
endmodule

// File: tb/tb_spi_port.sv
module tb_spi_port;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic irq, sclk_o, mosi_o, miso_o;
  logic miso_i = 1'b0, sclk_i = 1'b0, ss_n_i = 1'b1, mosi_i = 1'b0;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_port dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sclk_o(sclk_o),
    .mosi_o(mosi_o), .miso_i(miso_i), .sclk_i(sclk_i), .ss_n_i(ss_n_i),
    .mosi_i(mosi_i), .miso_o(miso_o)
  );

  function automatic int divisor(input logic [1:0] r);
    case (r) 2'd0: return 2; 2'd1: return 4; 2'd2: return 16; default: return 32; endcase
  endfunction
  function automatic logic [7:0] ctrl_word(input logic ie, en, ms, pol, pha, input logic [1:0] r);
    return {ie, en, 1'b0, ms, pol, pha, r};
  endfunction
  function automatic logic [7:0] stat_exp(input logic f, input logic c);
    return {f, c, 6'd0};
  endfunction

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask
  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  // behavioural slave attached to the master pins
  logic mdl_en = 1'b0, m_cpol = 1'b0, m_cpha = 1'b0;
  logic [7:0] slv_sh = '0, mcap = '0;
  always @(sclk_o) begin
    if (mdl_en) begin
      if (sclk_o != m_cpol) begin
        if (m_cpha) begin miso_i = slv_sh[7]; slv_sh = {slv_sh[6:0], 1'b0}; end
        else mcap = {mcap[6:0], mosi_o};
      end else begin
        if (m_cpha) mcap = {mcap[6:0], mosi_o};
        else begin slv_sh = {slv_sh[6:0], 1'b0}; miso_i = slv_sh[7]; end
      end
    end
  end

  task automatic master_xfer(input logic pol, input logic pha, input logic [1:0] r,
                             input logic [7:0] d, input logic [7:0] s);
    logic [7:0] v;
    int half;
    half = divisor(r) / 2;
    bus_write(8'h0A, ctrl_word(1'b1, 1'b1, 1'b1, pol, pha, r));
    @(negedge clk);
    m_cpol = pol; m_cpha = pha; slv_sh = s; mcap = '0; miso_i = s[7]; mdl_en = 1'b1;
    bus_write(8'h0C, d);
    repeat (16*half - 1) @(negedge clk);
    check("R5", "irq one clock before completion", {7'd0, irq}, 8'h00);
    @(negedge clk);
    check("R8", "irq at completion", {7'd0, irq}, 8'h01);
    check("R3", "serial clock back at idle level", {7'd0, sclk_o}, {7'd0, pol});
    bus_read(8'h0B, v); check("R5", "status after transfer", v, stat_exp(1'b1, 1'b0));
    bus_read(8'h0C, v); check("R4", "byte received from slave", v, s);
    check("R4", "byte seen by slave", mcap, d);
    bus_read(8'h0B, v); check("R6", "status after clear sequence", v, stat_exp(1'b0, 1'b0));
    mdl_en = 1'b0;
  endtask

  task automatic slave_xfer(input logic pol, input logic pha, input logic [7:0] d, input logic [7:0] m);
    logic [7:0] v, scap;
    scap = '0;
    sclk_i = pol; ss_n_i = 1'b1;
    bus_write(8'h0A, ctrl_word(1'b0, 1'b1, 1'b0, pol, pha, 2'b00));
    bus_write(8'h0C, d);
    repeat (4) @(negedge clk);
    ss_n_i = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      if (!pha) mosi_i = m[7-i];
      repeat (6) @(negedge clk);
      if (!pha) scap = {scap[6:0], miso_o};
      sclk_i = ~pol;
      if (pha) mosi_i = m[7-i];
      repeat (6) @(negedge clk);
      if (pha) scap = {scap[6:0], miso_o};
      sclk_i = pol;
    end
    repeat (8) @(negedge clk);
    ss_n_i = 1'b1;
    bus_read(8'h0B, v); check("R9", "slave status", v, stat_exp(1'b1, 1'b0));
    bus_read(8'h0C, v); check("R9", "slave received byte", v, m);
    check("R9", "slave transmitted byte", scap, d);
    bus_read(8'h0B, v); check("R6", "slave status cleared", v, stat_exp(1'b0, 1'b0));
  endtask

  initial begin
    logic [7:0] v;
    int seed_val;
    seed_val = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset and register layout
    bus_read(8'h0A, v); check("R1", "control after reset", v, 8'h00);
    bus_read(8'h0B, v); check("R1", "status after reset", v, 8'h00);
    check("R8", "irq after reset", {7'd0, irq}, 8'h00);
    bus_write(8'h0A, 8'hFF);
    bus_read(8'h0A, v); check("R1", "control readback unused bit", v, 8'hDF);
    bus_write(8'h0A, 8'h00);

    // R2 enable off: no transfer
    bus_write(8'h0A, ctrl_word(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00));
    bus_write(8'h0C, 8'h5A);
    repeat (40) @(negedge clk);
    check("R2", "clock idle while disabled", {7'd0, sclk_o}, 8'h01);
    bus_read(8'h0B, v); check("R2", "no flag while disabled", v, 8'h00);

    // R3/R4/R5 every rate and mode, directed patterns
    for (int r = 0; r < 4; r++)
      for (int m = 0; m < 4; m++)
        master_xfer(m[1], m[0], r[1:0], 8'hA5 ^ 8'(r*16 + m), 8'h3C ^ 8'(m*7 + r));
    master_xfer(1'b0, 1'b0, 2'b00, 8'hFF, 8'h00);
    master_xfer(1'b1, 1'b1, 2'b01, 8'h00, 8'hFF);

    // R6 data read before status read must not clear
    master_xfer(1'b0, 1'b1, 2'b00, 8'h81, 8'h7E);
    bus_write(8'h0A, ctrl_word(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00));
    @(negedge clk);
    m_cpol = 1'b0; m_cpha = 1'b0; slv_sh = 8'hC3; mcap = '0; miso_i = 1'b1; mdl_en = 1'b1;
    bus_write(8'h0C, 8'h11);
    repeat (30) @(negedge clk);
    bus_read(8'h0C, v); check("R6", "data read alone returns byte", v, 8'hC3);
    bus_read(8'h0B, v); check("R6", "flag survives lone data read", v, 8'h80);
    bus_read(8'h0C, v);
    bus_read(8'h0B, v); check("R6", "flag cleared by sequence", v, 8'h00);
    mdl_en = 1'b0;

    // R7 collision during a slow transfer
    bus_write(8'h0A, ctrl_word(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'b11));
    @(negedge clk);
    m_cpol = 1'b1; m_cpha = 1'b0; slv_sh = 8'h96; mcap = '0; miso_i = 1'b1; mdl_en = 1'b1;
    bus_write(8'h0C, 8'h4D);
    repeat (40) @(negedge clk);
    bus_write(8'h0C, 8'hE2);
    repeat (260) @(negedge clk);
    bus_read(8'h0B, v); check("R7", "collision and done flags", v, 8'hC0);
    bus_read(8'h0C, v); check("R7", "received byte of first transfer", v, 8'h96);
    check("R7", "shifted-out byte of first transfer", mcap, 8'h4D);
    bus_read(8'h0B, v); check("R7", "collision flag cleared", v, 8'h00);
    mdl_en = 1'b0;

    // R8 interrupt gated by enable
    bus_write(8'h0A, ctrl_word(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00));
    @(negedge clk);
    m_cpol = 1'b0; m_cpha = 1'b0; slv_sh = 8'h00; mcap = '0; miso_i = 1'b0; mdl_en = 1'b1;
    bus_write(8'h0C, 8'h01);
    repeat (30) @(negedge clk);
    check("R8", "irq low with enable off", {7'd0, irq}, 8'h00);
    bus_write(8'h0A, ctrl_word(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00));
    check("R8", "irq high once enabled", {7'd0, irq}, 8'h01);
    bus_read(8'h0B, v); bus_read(8'h0C, v);
    mdl_en = 1'b0;

    // R9 slave mode in every mode
    for (int m = 0; m < 4; m++) slave_xfer(m[1], m[0], 8'hB4 ^ 8'(m), 8'h69 ^ 8'(m*3));

    // random master transfers
    for (int k = 0; k < 24; k++) begin
      logic [7:0] rd_d, rd_s;
      logic [2:0] cfg;
      logic [1:0] rr;
      rd_d = 8'($urandom); rd_s = 8'($urandom); cfg = 3'($urandom); rr = 2'($urandom);
      master_xfer(cfg[1], cfg[0], rr, rd_d, rd_s);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule